// File: doc/BRIEF.md
# Leaf Page Entry Access Checker

This block decides, in one combinational step, whether a leaf entry reached by a page table walk allows the access being translated. It takes the entry's valid, read, write, execute and user flags, the low physical page number bits that a superpage must hold at zero, the number of those bits that the current level covers, the kind of access, the current privilege mode and two status controls. One control lets supervisor code touch user pages. The other lets loads read execute-only pages.

The block returns a single allow bit and a three-bit fault cause. When an entry breaks several rules at once, the cause reports the first broken rule in a fixed order. The walker places this checker after it has found a leaf and uses the allow bit to choose between finishing the translation and raising a page fault. The walker keeps updating the accessed and dirty bits, forming the address and reading memory.

Top module: `pte_leaf_checker`

## Requirements
- R1: An entry with the valid flag clear fails with cause 1, whatever its other inputs.
- R2: A valid entry whose read flag is clear and whose write flag is set (write only, or write plus execute) is a reserved encoding and fails with cause 2.
- R3: A page with the user flag set fails with cause 3 in any mode other than user (mode code 0), unless the supervisor-user control is on and the access is not a fetch.
- R4: A fetch (access code 0) from a user page in any mode other than user fails with cause 3, even with the supervisor-user control on.
- R5: A page with the user flag clear fails with cause 3 whenever the mode is not supervisor (mode code 1), including machine mode (code 3) and user mode.
- R6: With a shift of N, any set bit among bits 0 to N-1 of the low page number input fails with cause 4. A shift of 0 never fails this rule. A shift at or above the input width checks every bit.
- R7: A load (access code 1) passes the permission rule only if read is set, or if execute is set and the execute-readable control is on. That control has no effect on fetches or stores.
- R8: A store (access code 2) passes the permission rule only if write is set; otherwise it fails with cause 5.
- R9: A fetch passes the permission rule only if execute is set. Access code 3 always fails the permission rule. Both failures give cause 5.
- R10: Rules are ranked valid, reserved, privilege, alignment, permission, and the cause reports the first rule that fails.
- R11: The allow output is high exactly when the cause is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pte_valid | input | 1 | Entry valid flag |
| pte_read | input | 1 | Entry read flag |
| pte_write | input | 1 | Entry write flag |
| pte_exec | input | 1 | Entry execute flag |
| pte_user | input | 1 | Entry user-page flag |
| ppn_low | input | LEVEL_BITS*SUPER_LEVELS | Low physical page number bits tested for superpage alignment |
| page_shift | input | clog2(width of ppn_low + 1) | Number of low page number bits that must be zero at this level |
| access_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 unused code |
| cur_mode | input | 2 | 0 user, 1 supervisor, 2 other, 3 machine |
| sum_en | input | 1 | Lets non-fetch supervisor accesses reach user pages |
| mxr_en | input | 1 | Lets loads read execute-only pages |
| allow | output | 1 | High when the access is permitted |
| fault_cause | output | 3 | 0 pass, 1 invalid, 2 reserved, 3 privilege, 4 misaligned, 5 permission |

## Verification
The table vectors each break one rule in isolation, such as a write-only entry, a user page fetched under supervisor with the user-access control on, or an execute-only load with and without the readable control. A mismatch there points to a single rule. Further vectors stack several faults on one entry, so only a correct ranking returns the expected cause. An exhaustive sweep covers all 32 flag patterns, all access and mode codes, both controls, three shift values and four low page number patterns. This separates misalignment at a set bit just below the shift from a set bit at or above it, and shows that the user-access control never rescues a fetch.

// File: rtl/pte_chk_pkg.sv
package pte_chk_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_NONE  = 2'd3
  } access_e;

  typedef enum logic [1:0] {
    MODE_U = 2'd0,
    MODE_S = 2'd1,
    MODE_H = 2'd2,
    MODE_M = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    CAUSE_NONE     = 3'd0,
    CAUSE_INVALID  = 3'd1,
    CAUSE_RESERVED = 3'd2,
    CAUSE_PRIV     = 3'd3,
    CAUSE_MISALIGN = 3'd4,
    CAUSE_PERM     = 3'd5
  } cause_e;

  // Write without read is not a legal leaf encoding.
  function automatic logic rwx_reserved(input logic r, input logic w);
    return w & ~r;
  endfunction

  // Load readability, honouring the execute-readable control.
  function automatic logic load_readable(input logic r, input logic x, input logic mxr);
    return r | (x & mxr);
  endfunction

  // Privilege rule for one page kind.
  function automatic logic priv_blocks(input logic u, input mode_e m,
                                       input logic sum, input access_e a);
    if (u) return (m != MODE_U) && (!sum || (a == ACC_FETCH));
    return m != MODE_S;
  endfunction

endpackage

// File: rtl/pte_encode_rules.sv
module pte_encode_rules
  import pte_chk_pkg::*;
(
  input  logic v,
  input  logic r,
  input  logic w,
  output logic invalid_hit,
  output logic reserved_hit
);

  assign invalid_hit  = ~v;
  assign reserved_hit = rwx_reserved(r, w);

endmodule

// File: rtl/pte_priv_rules.sv
module pte_priv_rules
  import pte_chk_pkg::*;
(
  input  logic       u,
  input  logic [1:0] mode,
  input  logic       sum,
  input  logic [1:0] access,
  output logic       priv_hit
);

  mode_e   mode_q;
  access_e acc_q;
  logic    user_page_hit;
  logic    super_page_hit;

  assign mode_q         = mode_e'(mode);
  assign acc_q          = access_e'(access);
  assign user_page_hit  = u & priv_blocks(1'b1, mode_q, sum, acc_q);
  assign super_page_hit = ~u & priv_blocks(1'b0, mode_q, sum, acc_q);
  assign priv_hit       = user_page_hit | super_page_hit;

  always_comb begin
    // R4
    if (u && (mode_q != MODE_U) && (acc_q == ACC_FETCH))
      user_fetch_chk: assert (priv_hit) else $error("user page fetch outside user mode allowed");
    // R5
    if (!u && (mode_q == MODE_M))
      machine_super_page_chk: assert (priv_hit) else $error("machine mode reached supervisor page");
  end

endmodule

// File: rtl/pte_align_rules.sv
module pte_align_rules #(
  parameter int PPN_CHK_W = 18,
  parameter int SHIFT_W   = 5
) (
  input  logic [PPN_CHK_W-1:0] ppn_low,
  input  logic [SHIFT_W-1:0]   page_shift,
  output logic                 misalign_hit
);

  logic [PPN_CHK_W-1:0] below_shift;
  logic [PPN_CHK_W-1:0] stray_bits;

  for (genvar i = 0; i < PPN_CHK_W; i++) begin : g_mask
    assign below_shift[i] = page_shift > SHIFT_W'(i);
  end

  assign stray_bits   = ppn_low & below_shift;
  assign misalign_hit = |stray_bits;

  always_comb begin
    // R6
    if (page_shift == '0)
      zero_shift_chk: assert (!misalign_hit) else $error("shift of zero reported misaligned");
    // R6
    if (ppn_low[0] && (page_shift != '0))
      low_bit_chk: assert (misalign_hit) else $error("bit zero set but aligned");
  end

endmodule

// File: rtl/pte_access_rules.sv
module pte_access_rules
  import pte_chk_pkg::*;
(
  input  logic       r,
  input  logic       w,
  input  logic       x,
  input  logic       mxr,
  input  logic [1:0] access,
  output logic       perm_hit
);

  access_e acc_q;
  logic    load_ok;
  logic    store_ok;
  logic    fetch_ok;

  assign acc_q    = access_e'(access);
  assign load_ok  = load_readable(r, x, mxr);
  assign store_ok = w;
  assign fetch_ok = x;

  always_comb begin
    unique case (acc_q)
      ACC_FETCH: perm_hit = ~fetch_ok;
      ACC_LOAD:  perm_hit = ~load_ok;
      ACC_STORE: perm_hit = ~store_ok;
      default:   perm_hit = 1'b1;
    endcase
  end

  always_comb begin
    // R7
    if ((acc_q == ACC_LOAD) && r)
      load_r_ok_chk: assert (!perm_hit) else $error("readable page refused a load");
    // R9
    if (acc_q == ACC_NONE)
      unused_code_chk: assert (perm_hit) else $error("unused access code passed");
  end

endmodule

// File: rtl/pte_leaf_checker.sv
module pte_leaf_checker
  import pte_chk_pkg::*;
#(
  parameter  int LEVEL_BITS   = 9,
  parameter  int SUPER_LEVELS = 2,
  localparam int PPN_CHK_W    = LEVEL_BITS * SUPER_LEVELS,
  localparam int SHIFT_W      = $clog2(PPN_CHK_W + 1)
) (
  input  logic                 pte_valid,
  input  logic                 pte_read,
  input  logic                 pte_write,
  input  logic                 pte_exec,
  input  logic                 pte_user,
  input  logic [PPN_CHK_W-1:0] ppn_low,
  input  logic [SHIFT_W-1:0]   page_shift,
  input  logic [1:0]           access_kind,
  input  logic [1:0]           cur_mode,
  input  logic                 sum_en,
  input  logic                 mxr_en,
  output logic                 allow,
  output logic [2:0]           fault_cause
);

  logic   invalid_hit;
  logic   reserved_hit;
  logic   priv_hit;
  logic   misalign_hit;
  logic   perm_hit;
  cause_e cause;

  pte_encode_rules u_encode (
    .v            (pte_valid),
    .r            (pte_read),
    .w            (pte_write),
    .invalid_hit  (invalid_hit),
    .reserved_hit (reserved_hit)
  );

  pte_priv_rules u_priv (
    .u        (pte_user),
    .mode     (cur_mode),
    .sum      (sum_en),
    .access   (access_kind),
    .priv_hit (priv_hit)
  );

  pte_align_rules #(
    .PPN_CHK_W (PPN_CHK_W),
    .SHIFT_W   (SHIFT_W)
  ) u_align (
    .ppn_low      (ppn_low),
    .page_shift   (page_shift),
    .misalign_hit (misalign_hit)
  );

  pte_access_rules u_access (
    .r        (pte_read),
    .w        (pte_write),
    .x        (pte_exec),
    .mxr      (mxr_en),
    .access   (access_kind),
    .perm_hit (perm_hit)
  );

  // Ranked selection: the earliest failing rule names the fault.
  always_comb begin
    if (invalid_hit)       cause = CAUSE_INVALID;
    else if (reserved_hit) cause = CAUSE_RESERVED;
    else if (priv_hit)     cause = CAUSE_PRIV;
    else if (misalign_hit) cause = CAUSE_MISALIGN;
    else if (perm_hit)     cause = CAUSE_PERM;
    else                   cause = CAUSE_NONE;
  end

  assign fault_cause = cause;
  assign allow       = (cause == CAUSE_NONE);

  always_comb begin
    // R1
    if (!pte_valid)
      invalid_wins_chk: assert (fault_cause == CAUSE_INVALID) else $error("invalid entry not ranked first");
    // R2
    if (pte_valid && pte_write && !pte_read)
      reserved_code_chk: assert (fault_cause == CAUSE_RESERVED) else $error("reserved encoding missed");
    // R10
    if (fault_cause == CAUSE_MISALIGN)
      misalign_rank_chk: assert (!priv_hit && pte_valid) else $error("misalignment outranked privilege");
    // R11
    if (allow)
      allow_clean_chk: assert (!priv_hit && !misalign_hit && !perm_hit && pte_valid)
        else $error("allowed despite a failing rule");
  end

endmodule

// File: tb/pte_leaf_checker_tb.sv
module pte_leaf_checker_tb;

  localparam int PW = 18;
  localparam int SW = 5;

  logic          clk = 1'b0;
  logic          pte_valid, pte_read, pte_write, pte_exec, pte_user;
  logic [PW-1:0] ppn_low;
  logic [SW-1:0] page_shift;
  logic [1:0]    access_kind, cur_mode;
  logic          sum_en, mxr_en;
  logic          allow;
  logic [2:0]    fault_cause;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pte_leaf_checker u_dut (
    .pte_valid   (pte_valid),
    .pte_read    (pte_read),
    .pte_write   (pte_write),
    .pte_exec    (pte_exec),
    .pte_user    (pte_user),
    .ppn_low     (ppn_low),
    .page_shift  (page_shift),
    .access_kind (access_kind),
    .cur_mode    (cur_mode),
    .sum_en      (sum_en),
    .mxr_en      (mxr_en),
    .allow       (allow),
    .fault_cause (fault_cause)
  );

  // flags = {valid, read, write, exec, user}
  typedef struct packed {
    logic [4:0]    flags;
    logic [1:0]    acc;
    logic [1:0]    mode;
    logic          sum;
    logic          mxr;
    logic [SW-1:0] shift;
    logic [PW-1:0] ppn;
    logic [2:0]    exp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{5'b01110, 2'd1, 2'd1, 1'b0, 1'b0, 5'd0,  18'h00000, 3'd1}, // R1 invalid
    '{5'b10100, 2'd2, 2'd1, 1'b0, 1'b0, 5'd0,  18'h00000, 3'd2}, // R2 write only
    '{5'b10111, 2'd0, 2'd0, 1'b0, 1'b0, 5'd0,  18'h00000, 3'd2}, // R2 write+exec
    '{5'b11001, 2'd1, 2'd1, 1'b1, 1'b0, 5'd0,  18'h00000, 3'd0}, // R3 sum lets load
    '{5'b11001, 2'd1, 2'd1, 1'b0, 1'b0, 5'd0,  18'h00000, 3'd3}, // R3 no sum
    '{5'b10011, 2'd0, 2'd1, 1'b1, 1'b0, 5'd0,  18'h00000, 3'd3}, // R4 fetch, sum on
    '{5'b11000, 2'd1, 2'd3, 1'b0, 1'b0, 5'd0,  18'h00000, 3'd3}, // R5 machine mode
    '{5'b11000, 2'd1, 2'd0, 1'b0, 1'b0, 5'd0,  18'h00000, 3'd3}, // R5 user mode
    '{5'b11100, 2'd2, 2'd1, 1'b0, 1'b0, 5'd9,  18'h00100, 3'd4}, // R6 bit 8 set
    '{5'b11100, 2'd2, 2'd1, 1'b0, 1'b0, 5'd9,  18'h00200, 3'd0}, // R6 bit 9 fine
    '{5'b11100, 2'd2, 2'd1, 1'b0, 1'b0, 5'd18, 18'h20000, 3'd4}, // R6 top bit
    '{5'b10010, 2'd1, 2'd1, 1'b0, 1'b1, 5'd0,  18'h00000, 3'd0}, // R7 mxr load
    '{5'b10010, 2'd1, 2'd1, 1'b0, 1'b0, 5'd0,  18'h00000, 3'd5}, // R7 no mxr
    '{5'b11000, 2'd2, 2'd1, 1'b0, 1'b1, 5'd0,  18'h00000, 3'd5}, // R8 store no W
    '{5'b11100, 2'd0, 2'd1, 1'b0, 1'b1, 5'd0,  18'h00000, 3'd5}, // R9 fetch no X
    '{5'b11110, 2'd3, 2'd1, 1'b0, 1'b0, 5'd0,  18'h00000, 3'd5}, // R9 unused code
    '{5'b10001, 2'd2, 2'd1, 1'b0, 1'b0, 5'd9,  18'h00001, 3'd3}  // R10 priv over align/perm
  };

  // Independent reference built from the requirement text.
  function automatic logic [2:0] ref_cause(input logic [4:0] f, input logic [1:0] a,
                                           input logic [1:0] m, input logic s,
                                           input logic x_rd, input int sh,
                                           input logic [PW-1:0] p);
    logic v, r, w, x, u, blocked;
    logic [PW-1:0] mask;
    {v, r, w, x, u} = f;
    if (!v) return 3'd1;
    if (w && !r) return 3'd2;
    if (u) blocked = (m != 2'd0) && (!s || a == 2'd0);
    else   blocked = (m != 2'd1);
    if (blocked) return 3'd3;
    mask = (sh >= PW) ? '1 : ((PW'(1) << sh) - PW'(1));
    if ((p & mask) != '0) return 3'd4;
    case (a)
      2'd0: return x ? 3'd0 : 3'd5;
      2'd1: return (r || (x && x_rd)) ? 3'd0 : 3'd5;
      2'd2: return w ? 3'd0 : 3'd5;
      default: return 3'd5;
    endcase
  endfunction

  task automatic drive(input logic [4:0] f, input logic [1:0] a, input logic [1:0] m,
                       input logic s, input logic x_rd, input logic [SW-1:0] sh,
                       input logic [PW-1:0] p);
    @(posedge clk);
    {pte_valid, pte_read, pte_write, pte_exec, pte_user} = f;
    access_kind = a; cur_mode = m; sum_en = s; mxr_en = x_rd;
    page_shift = sh; ppn_low = p;
    @(negedge clk);
  endtask

  task automatic check_out(input string tag, input logic [2:0] exp);
    checks++;
    if (fault_cause !== exp || allow !== (exp == 3'd0)) begin
      fails++;
      $display("FAIL %s: cause=%0d allow=%0d expected cause=%0d allow=%0d",
               tag, fault_cause, allow, exp, (exp == 3'd0));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // Quiet state: all inputs low means an invalid entry (R1, R11).
    drive(5'b00000, 2'd0, 2'd0, 1'b0, 1'b0, '0, '0);
    check_out("R1 idle inputs", 3'd1);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].flags, VECS[i].acc, VECS[i].mode, VECS[i].sum, VECS[i].mxr,
            VECS[i].shift, VECS[i].ppn);
      check_out($sformatf("table vector %0d (R1..R10 as commented)", i), VECS[i].exp);
    end

    // R10 invalid outranks every other failure.
    drive(5'b00101, 2'd3, 2'd3, 1'b0, 1'b0, 5'd9, 18'h00001);
    check_out("R10 invalid over all", 3'd1);
    // R10 reserved outranks privilege and alignment.
    drive(5'b10101, 2'd0, 2'd1, 1'b0, 1'b0, 5'd9, 18'h00001);
    check_out("R10 reserved first", 3'd2);
    // R10 alignment outranks permission.
    drive(5'b10000, 2'd2, 2'd1, 1'b0, 1'b0, 5'd18, 18'h10000);
    check_out("R10 align over perm", 3'd4);

    // Exhaustive sweep: R2..R9 each rule, R10 ranking, R11 allow.
    for (int f = 0; f < 32; f++)
      for (int a = 0; a < 4; a++)
        for (int m = 0; m < 4; m++)
          for (int s = 0; s < 2; s++)
            for (int x = 0; x < 2; x++)
              for (int si = 0; si < 3; si++)
                for (int pi = 0; pi < 4; pi++) begin
                  int sh;
                  logic [PW-1:0] p;
                  sh = si * 9;
                  case (pi)
                    0: p = '0;
                    1: p = PW'(1);
                    2: p = PW'(1) << 8;
                    default: p = PW'(1) << 9;
                  endcase
                  drive(f[4:0], a[1:0], m[1:0], s[0], x[0], SW'(sh), p);
                  check_out($sformatf("R10 R11 sweep f=%0d a=%0d m=%0d s=%0d x=%0d sh=%0d p=%0d",
                                      f, a, m, s, x, sh, pi),
                            ref_cause(f[4:0], a[1:0], m[1:0], s[0], x[0], sh, p));
                end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule